// File: doc/BRIEF.md
# Triggered Multi-Pulse Glitch Sequencer

The block produces a timed series of short active-high pulses after a single trigger edge. Each pulse drives an external crowbar transistor that briefly pulls a target's core supply low. A small table holds up to `N_PAIRS` entries. Each entry is a wait count followed by a pulse length, and both are measured in clock cycles. A separate count register says how many entries take part in a run.

When a rising edge on the trigger input has passed the synchronizer, the sequencer walks the entries in index order. For each entry it waits out the delay and then holds the pulse high for the width. After the last valid entry it returns to idle. It then waits for the next trigger edge. Timing resolution is one clock period, which is about 5 ns at a clock near 200 MHz. A true output and an inverted output are both driven from registers, so either polarity of switch can be used.

Top module: `glitch_seq`

## Requirements
- R1: A rising edge on `trig_i` is detected through a two-stage synchronizer. If `trig_i` is sampled low at clock edge k-1 and high at edge k, then `busy_o` is high after edge k+2. Call edge k+2 the start edge.
- R2: The first pulse rises after start edge + D0, where D0 is entry 0's delay. It then stays high for exactly W0 cycles, where W0 is entry 0's width.
- R3: Entries run strictly in index order 0, 1, 2, .... After a pulse falls, `pulse_o` stays low for exactly the next entry's delay in cycles, and then the next pulse begins.
- R4: Only entries 0 to count-1 run. With a count of 0 a trigger has no effect. A count write above `N_PAIRS` stores `N_PAIRS`.
- R5: A width of 0 produces no pulse, and the next entry's delay starts counting at that same edge. A delay of 0 behaves as a delay of 1.
- R6: Operation is one-shot. When the last entry ends, `busy_o` falls in the same cycle that the last pulse falls (or at the last delay's expiry if the last width is 0). A trigger held high does not start another run; only a new rising edge does.
- R7: A trigger edge that arrives while `busy_o` is high is ignored, and the running schedule keeps its timing.
- R8: `pulse_n_o` is always the complement of `pulse_o`.
- R9: Table writes and count writes made while `busy_o` is high are dropped.
- R10: After reset, `busy_o` = 0, `pulse_o` = 0, `pulse_n_o` = 1, the count is 0, and every entry is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is the timing unit |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Asynchronous trigger; its rising edge starts a run |
| tbl_we_i | input | 1 | Write strobe for one table entry |
| tbl_addr_i | input | $clog2(N_PAIRS) | Entry index to write |
| tbl_dly_i | input | DLY_W | Delay count to store |
| tbl_wid_i | input | WID_W | Width count to store |
| cnt_we_i | input | 1 | Write strobe for the valid-entry count |
| cnt_i | input | $clog2(N_PAIRS+1) | Number of valid entries (clamped to N_PAIRS) |
| busy_o | output | 1 | High from the start edge until the schedule ends |
| pulse_o | output | 1 | Active-high glitch pulse |
| pulse_n_o | output | 1 | Inverted glitch pulse |

## Verification
The hardest conditions to reach from the ports are those that depend on events during a run: a second trigger edge or a table write that lands while the schedule is counting. The bench drops and raises the trigger a few cycles after the start edge. It issues entry and count writes while a long first delay is still counting. It then re-triggers and compares the cycle-exact pulse trace with the schedule that was loaded before the run. Zero widths and zero delays are placed in the middle and at the end of a schedule. This exercises the skip path, both on its own and where it ends the run.

// File: rtl/gs_pkg.sv
package gs_pkg;
   typedef enum logic [1:0] {
      GS_IDLE = 2'd0,
      GS_WAIT = 2'd1,
      GS_FIRE = 2'd2
   } gs_state_e;
endpackage

// File: rtl/gs_sync_edge.sv
module gs_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gs_sync_edge: STAGES must be at least 2");
   end

   // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], async_i};
   end

   assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/gs_table.sv
module gs_table #(
   parameter int N_PAIRS = 8,
   parameter int DLY_W   = 32,
   parameter int WID_W   = 16,
   parameter int IW      = 3,
   parameter int CW      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_i,
   input  logic             we_i,
   input  logic [IW-1:0]    waddr_i,
   input  logic [DLY_W-1:0] wdly_i,
   input  logic [WID_W-1:0] wwid_i,
   input  logic             cnt_we_i,
   input  logic [CW-1:0]    cnt_i,
   input  logic [IW-1:0]    raddr_i,
   output logic [DLY_W-1:0] rdly_o,
   output logic [WID_W-1:0] rwid_o,
   output logic [CW-1:0]    count_o
);
   logic [DLY_W-1:0] dly_q [N_PAIRS];
   logic [WID_W-1:0] wid_q [N_PAIRS];
   logic [CW-1:0]    cnt_q;

   for (genvar e = 0; e < N_PAIRS; e++) begin : g_entry
      logic hit;
      assign hit = we_i && !lock_i && (int'(waddr_i) == e);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dly_q[e] <= '0;
            wid_q[e] <= '0;
         end else if (hit) begin
            dly_q[e] <= wdly_i;
            wid_q[e] <= wwid_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_we_i && !lock_i)
         cnt_q <= (cnt_i > CW'(N_PAIRS)) ? CW'(N_PAIRS) : cnt_i;
   end

   assign rdly_o  = dly_q[raddr_i];
   assign rwid_o  = wid_q[raddr_i];
   assign count_o = cnt_q;
endmodule

// File: rtl/gs_engine.sv
module gs_engine
   import gs_pkg::*;
#(
   parameter int DLY_W = 32,
   parameter int WID_W = 16,
   parameter int IW    = 3,
   parameter int CW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CW-1:0]    count_i,
   input  logic [DLY_W-1:0] dly_i,
   input  logic [WID_W-1:0] wid_i,
   output logic [IW-1:0]    idx_o,
   output logic             busy_o,
   output logic             pulse_o,
   output logic             pulse_n_o
);
   gs_state_e        st_q, st_d;
   logic [IW-1:0]    idx_q, idx_d;
   logic [DLY_W-1:0] cnt_q, cnt_d;
   logic             last;

   assign last = (CW'(idx_q) + CW'(1)) == count_i;

   always_comb begin
      st_d  = st_q;
      idx_d = idx_q;
      cnt_d = cnt_q;
      unique case (st_q)
         GS_IDLE: begin
            if (start_i && count_i != '0) begin
               st_d  = GS_WAIT;
               idx_d = '0;
               cnt_d = DLY_W'(1);
            end
         end
         GS_WAIT: begin
            if (cnt_q >= dly_i) begin
               cnt_d = DLY_W'(1);
               if (wid_i != '0)
                  st_d = GS_FIRE;
               else if (last)
                  st_d = GS_IDLE;
               else
                  idx_d = idx_q + IW'(1);
            end else begin
               cnt_d = cnt_q + DLY_W'(1);
            end
         end
         GS_FIRE: begin
            if (cnt_q >= DLY_W'(wid_i)) begin
               cnt_d = DLY_W'(1);
               if (last) begin
                  st_d = GS_IDLE;
               end else begin
                  st_d  = GS_WAIT;
                  idx_d = idx_q + IW'(1);
               end
            end else begin
               cnt_d = cnt_q + DLY_W'(1);
            end
         end
         default: st_d = GS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= GS_IDLE;
         idx_q     <= '0;
         cnt_q     <= '0;
         pulse_o   <= 1'b0;
         pulse_n_o <= 1'b1;
      end else begin
         st_q      <= st_d;
         idx_q     <= idx_d;
         cnt_q     <= cnt_d;
         pulse_o   <= (st_d == GS_FIRE);
         pulse_n_o <= (st_d != GS_FIRE);
      end
   end

   assign busy_o = (st_q != GS_IDLE);
   assign idx_o  = idx_q;
endmodule

// File: rtl/glitch_seq.sv
module glitch_seq #(
   parameter int N_PAIRS     = 8,
   parameter int DLY_W       = 32,
   parameter int WID_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int IW = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1,
   localparam int CW = $clog2(N_PAIRS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             tbl_we_i,
   input  logic [IW-1:0]    tbl_addr_i,
   input  logic [DLY_W-1:0] tbl_dly_i,
   input  logic [WID_W-1:0] tbl_wid_i,
   input  logic             cnt_we_i,
   input  logic [CW-1:0]    cnt_i,
   output logic             busy_o,
   output logic             pulse_o,
   output logic             pulse_n_o
);
   if (N_PAIRS < 1) begin : g_bad_depth
      $error("glitch_seq: N_PAIRS must be at least 1");
   end
   if (WID_W > DLY_W) begin : g_bad_width
      $error("glitch_seq: WID_W must not exceed DLY_W");
   end

   logic             rise;
   logic [IW-1:0]    rd_idx;
   logic [DLY_W-1:0] cur_dly;
   logic [WID_W-1:0] cur_wid;
   logic [CW-1:0]    count;

   gs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (trig_i),
      .rise_o  (rise)
   );

   gs_table #(
      .N_PAIRS (N_PAIRS),
      .DLY_W   (DLY_W),
      .WID_W   (WID_W),
      .IW      (IW),
      .CW      (CW)
   ) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_i   (busy_o),
      .we_i     (tbl_we_i),
      .waddr_i  (tbl_addr_i),
      .wdly_i   (tbl_dly_i),
      .wwid_i   (tbl_wid_i),
      .cnt_we_i (cnt_we_i),
      .cnt_i    (cnt_i),
      .raddr_i  (rd_idx),
      .rdly_o   (cur_dly),
      .rwid_o   (cur_wid),
      .count_o  (count)
   );

   gs_engine #(
      .DLY_W (DLY_W),
      .WID_W (WID_W),
      .IW    (IW),
      .CW    (CW)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (rise),
      .count_i   (count),
      .dly_i     (cur_dly),
      .wid_i     (cur_wid),
      .idx_o     (rd_idx),
      .busy_o    (busy_o),
      .pulse_o   (pulse_o),
      .pulse_n_o (pulse_n_o)
   );
endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic trig_i,
   input logic busy_o,
   input logic pulse_o,
   input logic pulse_n_o
);
   AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o != pulse_n_o);                                   // R8
   AST_PULSE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> busy_o);                                     // R2
   AST_START_FROM_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(trig_i, SYNC_STAGES));           // R1
   AST_PULSE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o) |-> $past(busy_o));                       // R5
endmodule

bind glitch_seq gs_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig_i    (trig_i),
   .busy_o    (busy_o),
   .pulse_o   (pulse_o),
   .pulse_n_o (pulse_n_o)
);

// File: tb/tb_glitch_seq.sv
module tb_glitch_seq;
   localparam int N  = 8;
   localparam int DW = 32;
   localparam int WW = 16;
   localparam int IW = 3;
   localparam int CW = 4;
   localparam int MAXS = 600;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic          tbl_we = 1'b0;
   logic [IW-1:0] tbl_addr = '0;
   logic [DW-1:0] tbl_dly = '0;
   logic [WW-1:0] tbl_wid = '0;
   logic          cnt_we = 1'b0;
   logic [CW-1:0] cnt_v = '0;
   logic          busy_o, pulse_o, pulse_n_o;

   int tests = 0;
   int fails = 0;

   int sd [N];
   int sw [N];
   int sn;
   int exp_end;
   logic ep [MAXS];
   logic eb [MAXS];
   logic cp [MAXS];
   logic cb [MAXS];
   logic cn [MAXS];

   always #5 clk = ~clk;

   glitch_seq dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (trig),
      .tbl_we_i   (tbl_we),
      .tbl_addr_i (tbl_addr),
      .tbl_dly_i  (tbl_dly),
      .tbl_wid_i  (tbl_wid),
      .cnt_we_i   (cnt_we),
      .cnt_i      (cnt_v),
      .busy_o     (busy_o),
      .pulse_o    (pulse_o),
      .pulse_n_o  (pulse_n_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic wr_pair(input int i, input int d, input int w);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = IW'(i); tbl_dly = DW'(d); tbl_wid = WW'(w);
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic wr_count(input int c);
      @(negedge clk);
      cnt_we = 1'b1; cnt_v = CW'(c);
      @(negedge clk);
      cnt_we = 1'b0;
   endtask

   // Model: start edge is sample 2; each delay (min 1) then width
   function automatic void build_exp();
      int t;
      for (int j = 0; j < MAXS; j++) begin ep[j] = 1'b0; eb[j] = 1'b0; end
      t = 2;
      for (int i = 0; i < sn; i++) begin
         t += (sd[i] < 1) ? 1 : sd[i];
         for (int k = 0; k < sw[i]; k++) ep[t + k] = 1'b1;
         t += sw[i];
      end
      if (sn > 0)
         for (int j = 2; j < t; j++) eb[j] = 1'b1;
      exp_end = t;
   endfunction

   // Sample j is taken just after clock edge k+j, where trig_i was first high at edge k
   task automatic run_capture(input int len, input int drop_at, input int raise_at);
      @(negedge clk);
      trig = 1'b1;
      for (int j = 0; j < len; j++) begin
         @(posedge clk);
         #1;
         cp[j] = pulse_o; cb[j] = busy_o; cn[j] = pulse_n_o;
         if (j == drop_at)  trig = 1'b0;
         if (j == raise_at) trig = 1'b1;
      end
      trig = 1'b0;
      repeat (4) @(posedge clk);
   endtask

   task automatic compare_trace(input string req, input int len);
      int bad_p, bad_b, bad_c;
      bad_p = -1; bad_b = -1; bad_c = -1;
      for (int j = len - 1; j >= 0; j--) begin
         if (cp[j] !== ep[j]) bad_p = j;
         if (cb[j] !== eb[j]) bad_b = j;
         if (cn[j] !== ~cp[j]) bad_c = j;
      end
      check(bad_p < 0, {req, " pulse trace, actual/expected given at first bad sample"},
            (bad_p < 0) ? 0 : int'(cp[bad_p]), (bad_p < 0) ? 0 : int'(ep[bad_p]));
      check(bad_b < 0, {req, " busy trace"},
            (bad_b < 0) ? 0 : int'(cb[bad_b]), (bad_b < 0) ? 0 : int'(eb[bad_b]));
      check(bad_c < 0, "R8 pulse_n complement",
            (bad_c < 0) ? 0 : int'(cn[bad_c]), (bad_c < 0) ? 0 : int'(~cp[bad_c]));
   endtask

   task automatic load_sched(input int n);
      for (int i = 0; i < n; i++) wr_pair(i, sd[i], sw[i]);
      sn = n;
      wr_count(n);
   endtask

   task automatic t_reset();
      check(busy_o === 1'b0, "R10 busy after reset", int'(busy_o), 0);
      check(pulse_o === 1'b0, "R10 pulse after reset", int'(pulse_o), 0);
      check(pulse_n_o === 1'b1, "R10 pulse_n after reset", int'(pulse_n_o), 1);
      sn = 0;
      build_exp();
      run_capture(20, -1, -1);
      compare_trace("R4 R10 count zero ignores trigger", 20);
   endtask

   task automatic t_single();
      sd[0] = 5; sw[0] = 3;
      load_sched(1);
      build_exp();
      run_capture(exp_end + 10, -1, -1);
      compare_trace("R1 R2 single pair", exp_end + 10);
   endtask

   task automatic t_multi();
      sd[0] = 4; sw[0] = 2; sd[1] = 7; sw[1] = 5; sd[2] = 3; sw[2] = 1;
      load_sched(3);
      build_exp();
      run_capture(exp_end + 10, -1, -1);
      compare_trace("R3 ordered pairs", exp_end + 10);
   endtask

   task automatic t_zero();
      sd[0] = 0; sw[0] = 2; sd[1] = 3; sw[1] = 0; sd[2] = 2; sw[2] = 4;
      load_sched(3);
      build_exp();
      run_capture(exp_end + 10, -1, -1);
      compare_trace("R5 zero delay and mid zero width", exp_end + 10);
      sd[0] = 2; sw[0] = 3; sd[1] = 4; sw[1] = 0;
      load_sched(2);
      build_exp();
      run_capture(exp_end + 10, -1, -1);
      compare_trace("R5 R6 last width zero ends run", exp_end + 10);
   endtask

   task automatic t_count();
      sd[0] = 3; sw[0] = 2; sd[1] = 2; sw[1] = 2; sd[2] = 5; sw[2] = 6;
      load_sched(3);
      sn = 2;
      wr_count(2);
      build_exp();
      run_capture(exp_end + 15, -1, -1);
      compare_trace("R4 count limits entries", exp_end + 15);
      for (int i = 0; i < N; i++) begin sd[i] = i + 1; sw[i] = 1; end
      load_sched(N);
      wr_count(15);
      sn = N;
      build_exp();
      run_capture(exp_end + 10, -1, -1);
      compare_trace("R4 count clamps to depth", exp_end + 10);
   endtask

   task automatic t_retrig();
      sd[0] = 10; sw[0] = 3; sd[1] = 10; sw[1] = 3;
      load_sched(2);
      build_exp();
      // drop and re-raise trigger mid-run; hold high afterwards
      run_capture(exp_end + 30, 5, 8);
      compare_trace("R7 R6 retrigger ignored and level held", exp_end + 30);
      run_capture(exp_end + 10, -1, -1);
      compare_trace("R6 new edge rearms", exp_end + 10);
   endtask

   task automatic t_busy_write();
      int waited;
      sd[0] = 30; sw[0] = 2;
      load_sched(1);
      build_exp();
      @(negedge clk);
      trig = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      check(busy_o === 1'b1, "R9 busy during write attempt", int'(busy_o), 1);
      wr_pair(0, 2, 9);
      wr_count(0);
      trig = 1'b0;
      waited = 0;
      while (busy_o === 1'b1 && waited < 100) begin
         @(posedge clk); #1; waited++;
      end
      check(busy_o === 1'b0, "R6 busy falls after run", int'(busy_o), 0);
      repeat (3) @(posedge clk);
      run_capture(exp_end + 10, -1, -1);
      compare_trace("R9 writes while busy dropped", exp_end + 10);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_multi();
      t_zero();
      t_count();
      t_retrig();
      t_busy_write();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule